// File: doc/BRIEF.md
# Video RAM Bank Mapper

This block steers CPU accesses onto nine video RAM banks of unequal size. Each bank has a one-byte control register that switches it on, chooses one of up to eight placement entries and, where the entry allows, one of four placement offsets. From the selected entry the bank gets a region (one of eight), a starting slot and a repeat period. Within that region it covers as many consecutive 16 KiB slots as it has capacity, and the pattern repeats up to slot 63.

On each access the byte address is cut into 16 KiB slots. The block finds every bank whose region and placement cover that slot, which may be more than one. A write goes to all of them at once. A read returns the bitwise OR of their data. Each bank receives a word index that is masked to its own capacity, so a bank placed more than once aliases to the same storage.

The bank arrays sit outside the block. It drives per-bank enable, write-enable and word-index lines, and it takes back per-bank read data from synchronous single-port RAMs.

Top module: `vram_bank_mapper`

## Requirements
- R1: After reset all nine control registers are zero, no bank is hit (dbg_hit_o = 0) and cpu_rdata_o is zero.
- R2: In a control byte, bit 7 enables the bank, bits 2:0 choose the placement entry and bits 4:3 choose the offset index. A control write takes effect on the next clock edge, so an access presented in the same cycle still decodes with the old setting.
- R3: With bit 7 clear a bank is hit by no address, whatever the other bits hold.
- R4: The slot is address bits 23:14. Slot bits 9:7 must equal the entry's region. Slot bits 5:0 index the bank's placement, and slot bit 6 is ignored. dbg_hit_o bit b is set exactly when bank b is hit, and bank_en_o equals dbg_hit_o while cpu_req_i is high.
- R5: Entry 0 puts bank b in region 4 with period 64 at slot 0, 8, 16, 24, 32, 36, 37, 38 or 40 for b = 0 to 8. The banks span 8, 8, 8, 8, 4, 1, 1, 2 and 1 slots.
- R6: Entry 1 covers these banks. Banks 0 to 3 go to region 0, period 32, offsets 0/8/16/24. Bank 5 goes to region 0, period 32, offsets 0/1/4/5. Banks 4 and 6 go to region 0, period 32, slot 0. Bank 7 goes to region 1, period 4, slot 0. Bank 8 goes to region 1, period 4, slot 2.
- R7: Entry 2 covers these banks. Banks 0 and 1 go to region 2, period 16, offsets 0/8. Bank 5 goes to region 2, period 16, offsets 0/1/4/5. Banks 4, 6 and 7 go to region 2, period 16, slot 0. Bank 8 goes to region 3, period 1. Entry 4 puts bank 2 in region 1 and bank 3 in region 3, both with period 8 at slot 0. Where no offsets are listed, the offset index has no effect.
- R8: A read (cpu_req_i=1, cpu_we_i=0) returns on cpu_rdata_o one cycle later the OR of the data of all hit banks, or zero when no bank is hit. Without a read in the previous cycle, cpu_rdata_o is zero.
- R9: A write stores cpu_wdata_i into every hit bank. A write that hits nothing raises no bank enable. bank_we_o is zero unless a write is requested.
- R10: The word index sent to bank b is the byte address masked to the bank's capacity (128, 128, 128, 128, 64, 16, 16, 32 or 16 KiB) and shifted right by 2. Every placement of a bank therefore aliases the same words.
- R11: An entry not listed for a bank (for example entry 3 or 5 to 7, entry 2 for banks 2 and 3, or offset index 2 or 3 of entry 2 for banks 0 and 1) maps the bank nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_idx_i | input | IDX_W | Bank number of the control write |
| cfg_data_i | input | 8 | Control byte |
| cpu_req_i | input | 1 | Access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Merged read data, one cycle after the read |
| bank_en_o | output | 9 | Per-bank access enable |
| bank_we_o | output | 9 | Per-bank write enable |
| bank_addr_o | output | 9*BANK_AW | Per-bank word index, bank b at bits b*BANK_AW upward |
| bank_wdata_o | output | DATA_W | Write data to all banks |
| bank_rdata_i | input | 9*DATA_W | Per-bank synchronous read data |
| dbg_hit_o | output | 9 | Hit mask of the current address |

## Verification
The hit mask, bank enables and word indices are combinational in the presented address and the current control registers. A control write reaches that decode only after the edge on which it is written. Read data reaches cpu_rdata_o exactly one edge after the read request, because the bank RAMs and the registered hit mask both advance on that edge. The bench drives inputs on the falling edge and lets its model take each rising edge in the same order: it decodes with the old control state, writes or reads model memory, then applies the control write. On the next falling edge it compares the hit mask with the current decode and the read data with the value latched one edge earlier.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int NUM_BANKS  = 9;
  localparam int SLOT_SHIFT = 14;
  localparam int SLOT_W     = 10;

  typedef struct packed {
    logic            valid;
    logic [2:0]      region;
    logic [7:0]      base;
    logic [2:0]      per_log;
    logic [3:0][7:0] offs;
  } map_entry_t;

  // capacity in 16 KiB slots
  function automatic int bank_slots(input int b);
    case (b)
      0, 1, 2, 3: return 8;
      4:          return 4;
      7:          return 2;
      default:    return 1;
    endcase
  endfunction

  function automatic int bank_bytes_log2(input int b);
    return SLOT_SHIFT + $clog2(bank_slots(b));
  endfunction

  function automatic map_entry_t map_entry(input int b, input logic [2:0] sel);
    map_entry_t e;
    e = '0;
    case (sel)
      3'd0: begin
        e.valid   = 1'b1;
        e.region  = 3'd4;
        e.per_log = 3'd6;
        case (b)
          0: e.base = 8'd0;
          1: e.base = 8'd8;
          2: e.base = 8'd16;
          3: e.base = 8'd24;
          4: e.base = 8'd32;
          5: e.base = 8'd36;
          6: e.base = 8'd37;
          7: e.base = 8'd38;
          default: e.base = 8'd40;
        endcase
      end
      3'd1: begin
        e.valid = 1'b1;
        if (b >= 7) begin
          e.region  = 3'd1;
          e.per_log = 3'd2;
          e.base    = (b == 8) ? 8'd2 : 8'd0;
        end else begin
          e.region  = 3'd0;
          e.per_log = 3'd5;
          if (b < 4) begin
            e.offs[1] = 8'd8; e.offs[2] = 8'd16; e.offs[3] = 8'd24;
          end else if (b == 5) begin
            e.offs[1] = 8'd1; e.offs[2] = 8'd4; e.offs[3] = 8'd5;
          end
        end
      end
      3'd2: begin
        if (b == 8) begin
          e.valid   = 1'b1;
          e.region  = 3'd3;
          e.per_log = 3'd0;
        end else if (b != 2 && b != 3) begin
          e.valid   = 1'b1;
          e.region  = 3'd2;
          e.per_log = 3'd4;
          if (b < 2) begin
            // offsets 2,3 start beyond the map: nowhere
            e.offs[1] = 8'd8; e.offs[2] = 8'd128; e.offs[3] = 8'd128;
          end else if (b == 5) begin
            e.offs[1] = 8'd1; e.offs[2] = 8'd4; e.offs[3] = 8'd5;
          end
        end
      end
      3'd4: begin
        if (b == 2 || b == 3) begin
          e.valid   = 1'b1;
          e.region  = (b == 2) ? 3'd1 : 3'd3;
          e.per_log = 3'd3;
        end
      end
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/vbm_cfg_regs.sv
module vbm_cfg_regs #(
  parameter int N     = 9,
  parameter int IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]      data_i,
  output logic [N-1:0][7:0] cfg_o
);
  logic [N-1:0][7:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      for (int b = 0; b < N; b++) begin
        if (we_i && idx_i == IDX_W'(b)) cfg_q[b] <= data_i;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/vbm_bank_hit.sv
module vbm_bank_hit import vbm_pkg::*; #(
  parameter int BANK = 0
) (
  input  logic [7:0]        cfg_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              hit_o
);
  localparam int SIZE_SLOTS = bank_slots(BANK);

  map_entry_t e;
  logic [7:0] start, pos, rel, pmask;
  logic       unused_bit6;

  assign unused_bit6 = slot_i[6];

  always_comb begin
    e     = map_entry(BANK, cfg_i[2:0]);
    start = e.base + e.offs[cfg_i[4:3]];
    pos   = {2'b00, slot_i[5:0]};
    rel   = pos - start;
    pmask = (8'd1 << e.per_log) - 8'd1;
    hit_o = cfg_i[7] && e.valid
         && (slot_i[SLOT_W-1 -: 3] == e.region)
         && (pos >= start)
         && ((rel & pmask) < 8'(SIZE_SLOTS));
  end
endmodule

// File: rtl/vbm_read_merge.sv
module vbm_read_merge #(
  parameter int N  = 9,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_fire_i,
  input  logic [N-1:0]  hit_i,
  input  logic [N*DW-1:0] bank_rdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [N-1:0] rd_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_mask_q <= '0;
    else         rd_mask_q <= rd_fire_i ? hit_i : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N; b++) begin
      if (rd_mask_q[b]) rdata_o = rdata_o | bank_rdata_i[b*DW +: DW];
    end
  end
endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper import vbm_pkg::*; #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int BANK_AW = 15,
  parameter int IDX_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [IDX_W-1:0]          cfg_idx_i,
  input  logic [7:0]                cfg_data_i,
  input  logic                      cpu_req_i,
  input  logic                      cpu_we_i,
  input  logic [ADDR_W-1:0]         cpu_addr_i,
  input  logic [DATA_W-1:0]         cpu_wdata_i,
  output logic [DATA_W-1:0]         cpu_rdata_o,
  output logic [NUM_BANKS-1:0]      bank_en_o,
  output logic [NUM_BANKS-1:0]      bank_we_o,
  output logic [NUM_BANKS*BANK_AW-1:0] bank_addr_o,
  output logic [DATA_W-1:0]         bank_wdata_o,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata_i,
  output logic [NUM_BANKS-1:0]      dbg_hit_o
);
  logic [NUM_BANKS-1:0][7:0] cfg;
  logic [SLOT_W-1:0]         slot;
  logic [NUM_BANKS-1:0]      hit;
  logic                      unused_lo;

  assign slot      = cpu_addr_i[SLOT_SHIFT +: SLOT_W];
  assign unused_lo = ^cpu_addr_i[1:0];

  vbm_cfg_regs #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LW = bank_bytes_log2(b) - 2;
    vbm_bank_hit #(.BANK(b)) u_hit (
      .cfg_i  (cfg[b]),
      .slot_i (slot),
      .hit_o  (hit[b])
    );
    assign bank_addr_o[b*BANK_AW +: BANK_AW] = BANK_AW'(cpu_addr_i[2 +: LW]);
  end

  assign dbg_hit_o    = hit;
  assign bank_en_o    = cpu_req_i ? hit : '0;
  assign bank_we_o    = (cpu_req_i && cpu_we_i) ? hit : '0;
  assign bank_wdata_o = cpu_wdata_i;

  vbm_read_merge #(.N(NUM_BANKS), .DW(DATA_W)) u_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_fire_i    (cpu_req_i && !cpu_we_i),
    .hit_i        (hit),
    .bank_rdata_i (bank_rdata_i),
    .rdata_o      (cpu_rdata_o)
  );
endmodule

// File: rtl/vbm_checker.sv
module vbm_checker import vbm_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [IDX_W-1:0]     cfg_idx_i,
  input logic [7:0]           cfg_data_i,
  input logic                 cpu_req_i,
  input logic                 cpu_we_i,
  input logic [DATA_W-1:0]    cpu_rdata_o,
  input logic [NUM_BANKS-1:0] bank_en_o,
  input logic [NUM_BANKS-1:0] bank_we_o,
  input logic [NUM_BANKS-1:0] dbg_hit_o
);
  assert_en_matches_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |-> bank_en_o == dbg_hit_o);

  assert_idle_no_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> bank_en_o == '0);

  assert_no_stray_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_req_i && cpu_we_i) |-> bank_we_o == '0);

  assert_write_all_hits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i) |-> bank_we_o == dbg_hit_o);

  assert_idle_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_req_i && !cpu_we_i) |=> cpu_rdata_o == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dis
    assert_disable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_idx_i == IDX_W'(b) && !cfg_data_i[7]) |=> !dbg_hit_o[b]);
  end
endmodule

bind vram_bank_mapper vbm_checker u_vbm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_data_i  (cfg_data_i),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_rdata_o (cpu_rdata_o),
  .bank_en_o   (bank_en_o),
  .bank_we_o   (bank_we_o),
  .dbg_hit_o   (dbg_hit_o)
);

// File: tb/vram_bank_mapper_bench.sv
module vram_bank_mapper_bench;
  localparam int N = 9, DW = 32, BAW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [3:0] cfg_idx = '0; logic [7:0] cfg_dat = '0;
  logic req = 1'b0, we_s = 1'b0; logic [23:0] addr_s = '0; logic [31:0] wd_s = '0;
  logic [31:0] rdata; logic [N-1:0] bank_en, bank_we, dbg;
  logic [N*BAW-1:0] bank_addr; logic [31:0] bank_wd; logic [N*DW-1:0] ram_q = '0;

  int errs = 0, checks = 0;
  string phase = "R1";
  logic [7:0] m_cfg [N];
  logic [31:0] m_mem [int];
  logic [31:0] b_mem [int];
  logic [31:0] exp_rd = '0;
  int sz  [N] = '{8, 8, 8, 8, 4, 1, 1, 2, 1};
  int dvb [N] = '{0, 8, 16, 24, 32, 36, 37, 38, 40};

  always #4ns clk = ~clk;

  vram_bank_mapper u_vram_bank_mapper (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_dat),
    .cpu_req_i(req), .cpu_we_i(we_s), .cpu_addr_i(addr_s), .cpu_wdata_i(wd_s),
    .cpu_rdata_o(rdata), .bank_en_o(bank_en), .bank_we_o(bank_we), .bank_addr_o(bank_addr),
    .bank_wdata_o(bank_wd), .bank_rdata_i(ram_q), .dbg_hit_o(dbg)
  );

  // bank storage: synchronous single-port RAMs
  always @(posedge clk) begin
    int k;
    for (int b = 0; b < N; b++) begin
      if (bank_en[b]) begin
        k = b * 65536 + int'(bank_addr[b*BAW +: BAW]);
        if (bank_we[b]) b_mem[k] = bank_wd;
        else ram_q[b*DW +: DW] <= b_mem.exists(k) ? b_mem[k] : 32'h0;
      end
    end
  end

  function automatic logic [63:0] m_place(int b, logic [7:0] c, output int rg);
    int base = 0, per = 0;
    int o [4] = '{0, 0, 0, 0};
    logic [63:0] pl = '0;
    rg = -1;
    case (c[2:0])
      3'd0: begin rg = 4; per = 64; base = dvb[b]; end
      3'd1: begin
        rg = 0; per = 32;
        if (b < 4) o = '{0, 8, 16, 24};
        else if (b == 5) o = '{0, 1, 4, 5};
        else if (b >= 7) begin rg = 1; per = 4; base = (b == 8) ? 2 : 0; end
      end
      3'd2: begin
        if (b == 8) begin rg = 3; per = 1; end
        else if (b != 2 && b != 3) begin
          rg = 2; per = 16;
          if (b < 2) o = '{0, 8, 128, 128};
          if (b == 5) o = '{0, 1, 4, 5};
        end
      end
      3'd4: begin
        if (b == 2) begin rg = 1; per = 8; end
        else if (b == 3) begin rg = 3; per = 8; end
      end
      default: rg = -1;
    endcase
    if (c[7] && rg >= 0)
      for (int j = base + o[c[4:3]]; j < 64; j += per)
        for (int i = 0; i < sz[b]; i++)
          if (i + j < 64) pl[i+j] = 1'b1;
    return pl;
  endfunction

  function automatic logic [N-1:0] m_mask(logic [23:0] a);
    logic [N-1:0] m = '0;
    logic [63:0] pl;
    int rg;
    for (int b = 0; b < N; b++) begin
      pl = m_place(b, m_cfg[b], rg);
      if (rg == int'(a[23:21]) && pl[a[19:14]]) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic int lkey(int b, logic [23:0] a);
    return b * 65536 + ((int'(a) & (sz[b] * 16384 - 1)) >> 2);
  endfunction

  function automatic logic [23:0] ad(int r, int s, int off);
    return {3'(r), 7'(s), 14'(off)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one clock: model takes the edge, then outputs are compared mid-cycle
  task automatic step();
    logic [N-1:0] m;
    logic [31:0] nx;
    @(posedge clk);
    m = m_mask(addr_s);
    nx = '0;
    if (req && !we_s)
      for (int b = 0; b < N; b++)
        if (m[b] && m_mem.exists(lkey(b, addr_s))) nx = nx | m_mem[lkey(b, addr_s)];
    if (req && we_s)
      for (int b = 0; b < N; b++)
        if (m[b]) m_mem[lkey(b, addr_s)] = wd_s;
    if (cfg_we && cfg_idx < 4'd9) m_cfg[cfg_idx] = cfg_dat;
    exp_rd = nx;
    @(negedge clk);
    chk({phase, " hit mask"}, 32'(dbg), 32'(m_mask(addr_s)));
    chk({phase, " read data"}, rdata, exp_rd);
  endtask

  task automatic acc(logic w, logic [23:0] a, logic [31:0] d);
    cfg_we = 1'b0; req = 1'b1; we_s = w; addr_s = a; wd_s = d;
    step();
  endtask

  task automatic cfg(int idx, logic [7:0] d);
    req = 1'b0; cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_dat = d;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < N; b++) m_cfg[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R1";
    chk("R1 reset hit mask", 32'(dbg), 32'h0);
    chk("R1 reset read data", rdata, 32'h0);
    acc(1'b0, ad(4, 0, 0), '0);
    chk("R1 read before enable", rdata, 32'h0);

    phase = "R5";
    for (int b = 0; b < N; b++) cfg(b, 8'h80);
    for (int b = 0; b < N; b++) acc(1'b1, ad(4, dvb[b], 4*b), 32'hA000_0000 + 32'(b));
    for (int b = 0; b < N; b++) begin
      acc(1'b0, ad(4, dvb[b], 4*b), '0);
      chk("R5 direct view readback", rdata, 32'hA000_0000 + 32'(b));
    end

    phase = "R8";
    acc(1'b0, ad(4, 41, 0), '0);
    chk("R8 miss reads zero", rdata, 32'h0);

    phase = "R4";
    acc(1'b0, ad(4, 64 + dvb[3], 12), '0);
    chk("R4 slot bit 6 ignored", rdata, 32'hA000_0003);
    acc(1'b0, ad(0, 0, 0), '0);
    chk("R4 region mismatch", 32'(dbg), 32'h0);

    phase = "R10";
    acc(1'b1, ad(4, 39, 8), 32'h9999_0007);
    cfg(7, 8'h81);
    acc(1'b0, ad(1, 5, 8), '0);
    chk("R10 masked word index alias", rdata, 32'h9999_0007);

    phase = "R6";
    cfg(0, 8'h89);
    acc(1'b1, ad(0, 8, 32), 32'h1111_0000);
    acc(1'b0, ad(0, 40, 32), '0);
    chk("R6 offset 1 with period 32", rdata, 32'h1111_0000);
    cfg(5, 8'h99);
    acc(1'b0, ad(0, 5, 20), '0);
    chk("R6 bank 5 offset 3", rdata, 32'hA000_0005);

    phase = "R9";
    cfg(0, 8'h81); cfg(4, 8'h81);
    acc(1'b1, ad(0, 1, 64), 32'h0F0F_0000);
    cfg(0, 8'h80); cfg(4, 8'h80);
    acc(1'b0, ad(4, 1, 64), '0);
    chk("R9 broadcast reached bank 0", rdata, 32'h0F0F_0000);
    acc(1'b0, ad(4, 33, 64), '0);
    chk("R9 broadcast reached bank 4", rdata, 32'h0F0F_0000);
    acc(1'b1, ad(4, 48, 0), 32'hDEAD_BEEF);
    chk("R9 miss write raises no enable", 32'(bank_en), 32'h0);

    phase = "R8";
    acc(1'b1, ad(4, 1, 68), 32'h0000_00F1);
    acc(1'b1, ad(4, 33, 68), 32'h0000_1F00);
    cfg(0, 8'h81); cfg(4, 8'h81);
    acc(1'b0, ad(0, 1, 68), '0);
    chk("R8 overlap hit mask", 32'(dbg), 32'h011);
    chk("R8 overlap read is OR", rdata, 32'h0000_1FF1);

    phase = "R7";
    cfg(5, 8'h92);
    acc(1'b0, ad(2, 4, 20), '0);
    chk("R7 entry 2 bank 5 offset 2", rdata, 32'hA000_0005);

    phase = "R11";
    cfg(0, 8'h92); cfg(2, 8'h83); cfg(3, 8'h85);
    for (int r = 0; r < 8; r++)
      for (int s = 0; s < 64; s++) begin
        acc(1'b0, ad(r, s, 0), '0);
        chk("R11 unlisted entry maps nowhere", 32'(dbg & 9'h00D), 32'h0);
      end

    phase = "R3";
    acc(1'b0, ad(4, 37, 24), '0);
    chk("R3 enabled bank reads", rdata, 32'hA000_0006);
    cfg(6, 8'h00);
    acc(1'b0, ad(4, 37, 24), '0);
    chk("R3 disabled bank hit", 32'(dbg), 32'h0);
    chk("R3 disabled bank data", rdata, 32'h0);

    phase = "R2";
    req = 1'b1; we_s = 1'b0; addr_s = ad(4, 37, 24);
    cfg_we = 1'b1; cfg_idx = 4'd6; cfg_dat = 8'h80;
    step();
    cfg_we = 1'b0;
    chk("R2 same-cycle access uses old setting", rdata, 32'h0);
    chk("R2 new setting decodes after edge", 32'(dbg), 32'h040);
    acc(1'b0, ad(4, 37, 24), '0);
    chk("R2 read after enable", rdata, 32'hA000_0006);

    phase = "R4";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) cfg($urandom % 9, 8'($urandom));
      else acc(1'($urandom), ad($urandom % 6, $urandom % 128, ($urandom % 16) * 4), $urandom);
    end
    req = 1'b0;
    step();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule